// File: doc/BRIEF.md
# Packed-Array Descriptor Fetcher

This block is the descriptor-loading front end of a single DMA channel working from a packed array of descriptor sets. Software supplies a starting pointer and the length of the first set. Each time the transfer engine asks for its next work unit, the fetcher reads one descriptor set from memory. It reads one word at a time over a request/response port. It loads the words into the channel's parameter registers and then pulses a ready strobe so the engine can take the loaded values.

The sets carry no link pointers. Each set begins at the address directly after the last word of the one before it. A set can be anywhere from one to five words long. The words fill the registers in a fixed order: start address, configuration, X count, X modify, Y count. A short set overwrites only the leading registers, and the remaining registers keep their values from earlier work units. The configuration word of a set decides the length of the next set. It also decides whether fetching continues in array mode or stops so that a non-descriptor flow mode can take over.

Top module: `dsc_array_fetch`

## Requirements
- R1: After reset, rd_req and params_ready are 0, all five parameter outputs are 0, and the fetcher is disarmed: a next_unit pulse issues no read until software writes a pointer.
- R2: While no fetch is in progress, sw_ptr_we loads the read pointer and arms array mode, and sw_size_we sets the length of the next set (0 is treated as 1, and 6 or 7 as 5). Both writes are ignored while a fetch is in progress.
- R3: A fetch issues one read at a time. rd_req stays high with rd_addr unchanged until rd_valid is seen, and successive words of a set are read from addresses 4 bytes apart, starting at the pointer.
- R4: Word k of a set (k = 0..4) is loaded into, in order, start address, configuration, X count, X modify, Y count.
- R5: Parameter registers beyond the length of the current set keep the values they held before that set.
- R6: The first word of a set is read from the address 4 bytes after the last word of the previous set.
- R7: params_ready is a one-cycle pulse in the cycle after the last word's rd_valid, and the parameter outputs already hold the new set in that cycle. No further read starts until the next next_unit.
- R8: Configuration word bits [2:0] give the length of the next set, clamped as in R2, and bits [5:4] give the flow mode (1 = keep fetching the array, any other value = stop). A set without a configuration word leaves the previous length and mode in force.
- R9: When the most recently loaded flow mode is not 1, the current set completes with its ready pulse. After that, next_unit issues no read until software writes the pointer again.
- R10: A next_unit pulse that arrives while a fetch is in progress is ignored and does not queue another fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_ptr_we | input | 1 | Software write of the descriptor pointer (arms array mode) |
| sw_ptr_wdata | input | ADDR_W | Pointer value to load |
| sw_size_we | input | 1 | Software write of the first set's length |
| sw_size_wdata | input | 3 | Set length, 1 to 5 words |
| next_unit | input | 1 | Transfer engine requests the next work unit |
| rd_req | output | 1 | Memory read request, held until rd_valid |
| rd_addr | output | ADDR_W | Byte address of the word being read |
| rd_valid | input | 1 | Read data valid, completes the request |
| rd_data | input | 32 | Read data word |
| params_ready | output | 1 | One-cycle strobe: a new set has been loaded |
| prm_start | output | 32 | Start address parameter |
| prm_cfg | output | 32 | Configuration parameter |
| prm_xcnt | output | 32 | X count parameter |
| prm_xmod | output | 32 | X modify parameter |
| prm_ycnt | output | 32 | Y count parameter |

## Verification
A wrong slot counter or set length shows up one cycle after the last rd_valid of a set, as a misplaced or missing params_ready pulse or a word loaded into the wrong parameter output. A pointer that drifts shows up on the very next request as a wrong rd_addr, and the bench logs every request address. A wrong flow-mode or length register stays hidden until the following next_unit. At that point it shows as a set of the wrong length or as reads that should not happen. Because of this, the directed sequences always request one more unit after each mode or length change.

// File: rtl/dsc_fetch_pkg.sv
package dsc_fetch_pkg;

    localparam int unsigned WORD_W       = 32;
    localparam int unsigned NUM_PARAMS   = 5;
    localparam int unsigned SIZE_W       = 3;
    localparam int unsigned MODE_W       = 2;
    localparam int unsigned CFG_SIZE_LSB = 0;
    localparam int unsigned CFG_MODE_LSB = 4;
    localparam int unsigned STEP_BYTES   = WORD_W / 8;

    typedef enum logic [MODE_W-1:0] {
        FLOW_STOP  = 2'd0,
        FLOW_ARRAY = 2'd1,
        FLOW_ALT2  = 2'd2,
        FLOW_ALT3  = 2'd3
    } flow_mode_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_READ = 1'b1
    } fetch_state_e;

    typedef enum logic [SIZE_W-1:0] {
        SLOT_START = 3'd0,
        SLOT_CFG   = 3'd1,
        SLOT_XCNT  = 3'd2,
        SLOT_XMOD  = 3'd3,
        SLOT_YCNT  = 3'd4
    } param_slot_e;

    typedef struct packed {
        logic [WORD_W-1:0] ycnt;
        logic [WORD_W-1:0] xmod;
        logic [WORD_W-1:0] xcnt;
        logic [WORD_W-1:0] cfg;
        logic [WORD_W-1:0] start;
    } param_set_t;

    function automatic logic [SIZE_W-1:0] clamp_size(input logic [SIZE_W-1:0] raw);
        if (raw == '0)
            return SIZE_W'(1);
        else if (raw > SIZE_W'(NUM_PARAMS))
            return SIZE_W'(NUM_PARAMS);
        else
            return raw;
    endfunction

endpackage

// File: rtl/dsc_ptr_track.sv
module dsc_ptr_track #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned STEP   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (step)
            ptr <= ptr + STEP_V;
    end

    a_r2_load_wins: assert property (@(posedge clk) disable iff (rst)
        load |=> ptr == $past(load_val));
endmodule

// File: rtl/dsc_param_bank.sv
module dsc_param_bank
    import dsc_fetch_pkg::*;
#(
    parameter int unsigned NUM = NUM_PARAMS,
    parameter int unsigned W   = WORD_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [SIZE_W-1:0]     wr_slot,
    input  logic [W-1:0]          wr_data,
    output logic [NUM-1:0][W-1:0] regs
);
    generate
        for (genvar g = 0; g < NUM; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs[g] <= '0;
                else if (wr_en && wr_slot == SIZE_W'(g))
                    regs[g] <= wr_data;
            end
        end
    endgenerate

    a_r4_slot_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_slot < SIZE_W'(NUM));
    a_r5_untouched_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> regs == $past(regs));
endmodule

// File: rtl/dsc_fetch_ctrl.sv
module dsc_fetch_ctrl
    import dsc_fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_ptr_we,
    input  logic              sw_size_we,
    input  logic [SIZE_W-1:0] sw_size_wdata,
    input  logic              next_unit,
    input  logic              rd_valid,
    input  logic [SIZE_W-1:0] cfg_size_raw,
    input  logic [MODE_W-1:0] cfg_mode_raw,
    output logic              ptr_load,
    output logic              ptr_step,
    output logic              rd_req,
    output logic              bank_we,
    output logic [SIZE_W-1:0] bank_slot,
    output logic              params_ready
);
    fetch_state_e      state;
    logic [SIZE_W-1:0] slot;
    logic [SIZE_W-1:0] cur_size;
    logic [SIZE_W-1:0] nxt_size;
    flow_mode_e        nxt_mode;
    logic              idle;
    logic              accept;
    logic              last_word;

    assign idle      = (state == ST_IDLE);
    assign accept    = (state == ST_READ) && rd_valid;
    assign last_word = (slot == cur_size - SIZE_W'(1));

    assign rd_req    = (state == ST_READ);
    assign ptr_load  = idle && sw_ptr_we;
    assign ptr_step  = accept;
    assign bank_we   = accept;
    assign bank_slot = slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            slot         <= '0;
            cur_size     <= SIZE_W'(1);
            nxt_size     <= SIZE_W'(1);
            nxt_mode     <= FLOW_STOP;
            params_ready <= 1'b0;
        end else begin
            params_ready <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (sw_ptr_we)
                        nxt_mode <= FLOW_ARRAY;
                    if (sw_size_we)
                        nxt_size <= clamp_size(sw_size_wdata);
                    if (next_unit && nxt_mode == FLOW_ARRAY) begin
                        state    <= ST_READ;
                        slot     <= '0;
                        cur_size <= nxt_size;
                    end
                end
                ST_READ: begin
                    if (rd_valid) begin
                        if (slot == SIZE_W'(SLOT_CFG)) begin
                            nxt_size <= clamp_size(cfg_size_raw);
                            nxt_mode <= flow_mode_e'(cfg_mode_raw);
                        end
                        if (last_word) begin
                            state        <= ST_IDLE;
                            params_ready <= 1'b1;
                        end else begin
                            slot <= slot + SIZE_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r7_ready_single: assert property (@(posedge clk) disable iff (rst)
        params_ready |=> !params_ready);
    a_r7_ready_follows_read: assert property (@(posedge clk) disable iff (rst)
        params_ready |-> $past(rd_req && rd_valid));
    a_r7_no_prefetch: assert property (@(posedge clk) disable iff (rst)
        params_ready |-> !rd_req);
    a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_valid |=> rd_req);
    a_r9_stopped_stays: assert property (@(posedge clk) disable iff (rst)
        !rd_req && nxt_mode != FLOW_ARRAY |=> !rd_req);
    a_r8_size_legal: assert property (@(posedge clk) disable iff (rst)
        cur_size != '0 && cur_size <= SIZE_W'(NUM_PARAMS));
endmodule

// File: rtl/dsc_array_fetch.sv
module dsc_array_fetch
    import dsc_fetch_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_ptr_we,
    input  logic [ADDR_W-1:0] sw_ptr_wdata,
    input  logic              sw_size_we,
    input  logic [2:0]        sw_size_wdata,
    input  logic              next_unit,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [31:0]       rd_data,
    output logic              params_ready,
    output logic [31:0]       prm_start,
    output logic [31:0]       prm_cfg,
    output logic [31:0]       prm_xcnt,
    output logic [31:0]       prm_xmod,
    output logic [31:0]       prm_ycnt
);
    logic                             ptr_load;
    logic                             ptr_step;
    logic                             bank_we;
    logic [SIZE_W-1:0]                bank_slot;
    logic [SIZE_W-1:0]                cfg_size_raw;
    logic [MODE_W-1:0]                cfg_mode_raw;
    logic [NUM_PARAMS-1:0][WORD_W-1:0] bank_regs;
    param_set_t                       params;

    assign cfg_size_raw = rd_data[CFG_SIZE_LSB +: SIZE_W];
    assign cfg_mode_raw = rd_data[CFG_MODE_LSB +: MODE_W];

    dsc_fetch_ctrl i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sw_ptr_we    (sw_ptr_we),
        .sw_size_we   (sw_size_we),
        .sw_size_wdata(sw_size_wdata),
        .next_unit    (next_unit),
        .rd_valid     (rd_valid),
        .cfg_size_raw (cfg_size_raw),
        .cfg_mode_raw (cfg_mode_raw),
        .ptr_load     (ptr_load),
        .ptr_step     (ptr_step),
        .rd_req       (rd_req),
        .bank_we      (bank_we),
        .bank_slot    (bank_slot),
        .params_ready (params_ready)
    );

    dsc_ptr_track #(.ADDR_W(ADDR_W), .STEP(STEP_BYTES)) i_ptr (
        .clk     (clk),
        .rst     (rst),
        .load    (ptr_load),
        .load_val(sw_ptr_wdata),
        .step    (ptr_step),
        .ptr     (rd_addr)
    );

    dsc_param_bank #(.NUM(NUM_PARAMS), .W(WORD_W)) i_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bank_we),
        .wr_slot(bank_slot),
        .wr_data(rd_data),
        .regs   (bank_regs)
    );

    assign params    = param_set_t'(bank_regs);
    assign prm_start = params.start;
    assign prm_cfg   = params.cfg;
    assign prm_xcnt  = params.xcnt;
    assign prm_xmod  = params.xmod;
    assign prm_ycnt  = params.ycnt;

    a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_valid |=> $stable(rd_addr));
    a_r6_word_stride: assert property (@(posedge clk) disable iff (rst)
        rd_req && rd_valid |=> rd_addr == $past(rd_addr) + ADDR_W'(STEP_BYTES));
    a_r2_busy_ignores_ptr: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_valid |=> rd_addr == $past(rd_addr));
endmodule

// File: tb/test_dsc_array_fetch.sv
module test_dsc_array_fetch;
    logic        clk = 1'b0;
    logic        rst;
    logic        sw_ptr_we = 1'b0;
    logic [31:0] sw_ptr_wdata = '0;
    logic        sw_size_we = 1'b0;
    logic [2:0]  sw_size_wdata = '0;
    logic        next_unit = 1'b0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        params_ready;
    logic [31:0] prm_start, prm_cfg, prm_xcnt, prm_xmod, prm_ycnt;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int wait_cnt = 0;
    int log_n = 0;
    logic [31:0] log_addr [0:255];
    logic [31:0] mem [0:63];

    localparam logic [31:0] BASE = 32'h0000_1000;

    always #2 clk = ~clk;

    dsc_array_fetch i_dsc_array_fetch (
        .clk(clk), .rst(rst),
        .sw_ptr_we(sw_ptr_we), .sw_ptr_wdata(sw_ptr_wdata),
        .sw_size_we(sw_size_we), .sw_size_wdata(sw_size_wdata),
        .next_unit(next_unit),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .params_ready(params_ready),
        .prm_start(prm_start), .prm_cfg(prm_cfg), .prm_xcnt(prm_xcnt),
        .prm_xmod(prm_xmod), .prm_ycnt(prm_ycnt)
    );

    // memory model: one response per request after lat idle cycles
    always @(negedge clk) begin
        if (rst) begin
            rd_valid = 1'b0;
            wait_cnt = 0;
        end else begin
            rd_valid = 1'b0;
            if (rd_req) begin
                if (wait_cnt >= lat) begin
                    int idx;
                    idx = int'((rd_addr - BASE) >> 2);
                    rd_data = (idx >= 0 && idx < 64) ? mem[idx] : 32'hDEAD_BEEF;
                    rd_valid = 1'b1;
                    if (log_n < 256) log_addr[log_n] = rd_addr;
                    log_n++;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    function automatic logic [31:0] mk_cfg(input int size, input int mode);
        return 32'h00AB_0000 | 32'((mode & 3) << 4) | 32'(size & 7);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_ptr(input logic [31:0] a);
        @(negedge clk); sw_ptr_we = 1'b1; sw_ptr_wdata = a;
        @(negedge clk); sw_ptr_we = 1'b0;
    endtask

    task automatic wr_size(input logic [2:0] s);
        @(negedge clk); sw_size_we = 1'b1; sw_size_wdata = s;
        @(negedge clk); sw_size_we = 1'b0;
    endtask

    task automatic pulse_next();
        @(negedge clk); next_unit = 1'b1;
        @(negedge clk); next_unit = 1'b0;
    endtask

    task automatic wait_ready(input string tag);
        int k;
        for (k = 0; k < 300; k++) begin
            @(negedge clk);
            if (params_ready) break;
        end
        chk({tag, " ready seen"}, 32'(params_ready), 32'd1);
    endtask

    task automatic check_set(input string tag, input int n0, input int exp_n, input logic [31:0] first);
        chk({tag, " word count"}, 32'(log_n - n0), 32'(exp_n));
        for (int k = 0; k < exp_n; k++)
            chk({tag, " read address"}, log_addr[n0 + k], first + 32'(4 * k));
        @(negedge clk);
        chk({tag, " R7 ready one cycle"}, 32'(params_ready), 32'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk({tag, " R7 no fetch before request"}, 32'(rd_req), 32'd0);
        end
        chk({tag, " R7 no extra reads"}, 32'(log_n - n0), 32'(exp_n));
    endtask

    task automatic run_set(input string tag, input int exp_n, input logic [31:0] first);
        int n0;
        n0 = log_n;
        pulse_next();
        wait_ready(tag);
        check_set(tag, n0, exp_n, first);
    endtask

    task automatic check_params(input string tag, input logic [31:0] s, input logic [31:0] c,
                                input logic [31:0] x, input logic [31:0] m, input logic [31:0] y);
        chk({tag, " start"}, prm_start, s);
        chk({tag, " cfg"},   prm_cfg, c);
        chk({tag, " xcnt"},  prm_xcnt, x);
        chk({tag, " xmod"},  prm_xmod, m);
        chk({tag, " ycnt"},  prm_ycnt, y);
    endtask

    task automatic expect_no_fetch(input string tag);
        int n0;
        n0 = log_n;
        pulse_next();
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk({tag, " rd_req low"}, 32'(rd_req), 32'd0);
        end
        chk({tag, " no reads"}, 32'(log_n - n0), 32'd0);
    endtask

    task automatic t_reset();
        check_params("R1 reset", 32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
        chk("R1 reset rd_req", 32'(rd_req), 32'd0);
        chk("R1 reset params_ready", 32'(params_ready), 32'd0);
        expect_no_fetch("R1 disarmed");
    endtask

    task automatic t_full_set();
        lat = 0;
        wr_ptr(BASE);
        wr_size(3'd5);
        run_set("R3 R4 full set", 5, BASE);
        check_params("R4 full set", 32'hA000_0000, mk_cfg(2, 1), 32'h10, 32'h4, 32'h3);
    endtask

    task automatic t_short_sets();
        lat = 1;
        run_set("R6 R8 two-word set", 2, BASE + 32'h14);
        check_params("R5 two-word set", 32'hA000_1000, mk_cfg(1, 1), 32'h10, 32'h4, 32'h3);
        run_set("R6 one-word set", 1, BASE + 32'h1C);
        check_params("R5 one-word set", 32'hA000_2000, mk_cfg(1, 1), 32'h10, 32'h4, 32'h3);
        run_set("R8 size kept without cfg", 1, BASE + 32'h20);
        chk("R5 start updated", prm_start, 32'hA000_3000);
    endtask

    task automatic t_busy_ignore();
        int n0;
        lat = 3;
        wr_ptr(BASE + 32'h40);
        wr_size(3'd3);
        n0 = log_n;
        pulse_next();
        @(negedge clk);
        next_unit = 1'b1; sw_ptr_we = 1'b1; sw_ptr_wdata = BASE + 32'h400;
        sw_size_we = 1'b1; sw_size_wdata = 3'd5;
        @(negedge clk);
        next_unit = 1'b0; sw_ptr_we = 1'b0; sw_size_we = 1'b0;
        wait_ready("R10 busy");
        check_set("R10 R2 busy", n0, 3, BASE + 32'h40);
        check_params("R4 three-word set", 32'hB000_0000, mk_cfg(3, 1), 32'h22, 32'h4, 32'h3);
        run_set("R2 R6 ptr write ignored while busy", 3, BASE + 32'h4C);
    endtask

    task automatic t_clamp();
        lat = 0;
        run_set("R8 size 7 clamps to 5", 5, BASE + 32'h58);
        check_params("R8 clamp set", 32'hC000_0000, mk_cfg(0, 1), 32'h44, 32'h8, 32'h5);
        run_set("R8 size 0 acts as 1", 1, BASE + 32'h6C);
        check_params("R5 after one-word", 32'hC000_1000, mk_cfg(0, 1), 32'h44, 32'h8, 32'h5);
    endtask

    task automatic t_stop();
        lat = 2;
        wr_ptr(BASE + 32'h80);
        wr_size(3'd2);
        run_set("R9 set switching to stop", 2, BASE + 32'h80);
        check_params("R9 stop set", 32'hD000_0000, mk_cfg(4, 0), 32'h44, 32'h8, 32'h5);
        expect_no_fetch("R9 stopped");
        wr_ptr(BASE + 32'h80);
        run_set("R2 R9 pointer rewrite re-arms", 4, BASE + 32'h80);
        check_params("R9 re-armed set", 32'hD000_0000, mk_cfg(4, 0), 32'h55, 32'h66, 32'h5);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'hEEEE_0000 | 32'(i);
        mem[0] = 32'hA000_0000; mem[1] = mk_cfg(2, 1); mem[2] = 32'h10; mem[3] = 32'h4; mem[4] = 32'h3;
        mem[5] = 32'hA000_1000; mem[6] = mk_cfg(1, 1);
        mem[7] = 32'hA000_2000;
        mem[8] = 32'hA000_3000;
        mem[16] = 32'hB000_0000; mem[17] = mk_cfg(3, 1); mem[18] = 32'h22;
        mem[19] = 32'hB000_1000; mem[20] = mk_cfg(7, 1); mem[21] = 32'h33;
        mem[22] = 32'hC000_0000; mem[23] = mk_cfg(0, 1); mem[24] = 32'h44; mem[25] = 32'h8; mem[26] = 32'h5;
        mem[27] = 32'hC000_1000;
        mem[32] = 32'hD000_0000; mem[33] = mk_cfg(4, 0); mem[34] = 32'h55; mem[35] = 32'h66;

        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_set();
        t_short_sets();
        t_busy_ignore();
        t_clamp();
        t_stop();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule